// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide, two-address register front end of a classic eight-line priority interrupt controller. A single address bit picks between the command port and the data port. A write to the command port either starts an initialization sequence or issues an operation command. Data-port writes are consumed by the initialization sequence while it runs. When no sequence runs, they load the interrupt mask.

The block keeps the settings that come out of initialization: the vector base, nested and auto end-of-interrupt modes, and whether the optional fourth word is expected. It also keeps the operation settings: special mask, read select, rotate on auto end-of-interrupt and the one-shot poll arm. Operation commands become single-cycle strobes for end-of-interrupt, rotation and priority setting, each with a line number. The priority resolver and the request latch sit outside the block. They supply the request bits, the in-service bits and the highest pending line, and they take the strobes back.

Reads are registered. Outside poll mode, a read returns the mask, the request register or the in-service register. An armed poll read returns the pending line with bit 7 set as a valid flag, or 0x07 when nothing is pending. It also pulses a clear toward the resolver, and then poll mode disarms.

Top module: `irq_cmd_seq`

## Requirements
- R1: A command-port write (addr=0) with bit 4 set starts initialization. The next cycle shows `init_busy`=1 and a single-cycle `init_pulse`, which tells the resolver to drop its priority base. Bit 0 of that write is kept as "fourth word expected".
- R2: The first data-port write (addr=1) after initialization starts sets `vec_base` to the written value with bits 2:0 forced to zero.
- R3: The second data-port write of the sequence goes on to the mode word if the fourth word is expected. Otherwise it ends the sequence (`init_busy`=0).
- R4: The mode word (fourth word) sets `sfnm` from bit 4 and `auto_eoi` from bit 1, then ends the sequence.
- R5: A data-port write outside initialization loads `mask`. Data writes during initialization leave `mask` unchanged.
- R6: A command write with bit 4=0 and bit 3=1 is a read/mode command. Bit 2=1 arms poll. Bit 1=1 copies bit 0 into read select (1 = in-service, 0 = request). Bit 6=1 copies bit 5 into `special_mask`. Cleared enable bits leave the setting unchanged.
- R7: A command write with bits 4 and 3 both 0 decodes bits 7:5. Codes 0 and 4 set `rot_auto_eoi` to bit 7. Code 1 pulses `eoi_ns`. Code 5 pulses `eoi_ns` with `eoi_rot`. Code 3 pulses `eoi_sp`. Code 7 pulses `eoi_sp` with `eoi_rot`. Code 6 pulses `prio_set`. Code 2 does nothing. Bits 2:0 go to `cmd_line`. Strobes last one cycle after the write.
- R8: A read while poll is armed returns, one cycle later, 0x80 OR `pend_line` together with a one-cycle `poll_clr` and `poll_line`=`pend_line` when `pend_valid`=1. It returns 0x07 with no clear when `pend_valid`=0. Either way poll disarms, so the next read is a normal read.
- R9: A normal read returns, one cycle later, `mask` for addr=1. For addr=0 it returns `isr_in` when read select is 1 and `req_in` when it is 0.
- R10: Initialization clears `mask`, `special_mask` and read select. It clears `sfnm` and `auto_eoi` only when the fourth word is not expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| req_in | input | 8 | Request register from the request latch |
| isr_in | input | 8 | In-service register from the resolver |
| pend_valid | input | 1 | Resolver has a line that should be served |
| pend_line | input | 3 | That line's number |
| rdata | output | 8 | Registered read data |
| vec_base | output | 8 | Vector base, low three bits zero |
| mask | output | 8 | Interrupt mask |
| init_busy | output | 1 | Initialization sequence in progress |
| init_pulse | output | 1 | One-cycle strobe when initialization starts |
| sfnm | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_auto_eoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| eoi_ns | output | 1 | Non-specific end-of-interrupt strobe |
| eoi_sp | output | 1 | Specific end-of-interrupt strobe |
| eoi_rot | output | 1 | Rotation qualifier for the EOI strobes |
| prio_set | output | 1 | Set-priority strobe |
| cmd_line | output | 3 | Line number of the last operation command |
| poll_clr | output | 1 | Poll hit: clear this line's request and in-service bits |
| poll_line | output | 3 | Line cleared by the last poll hit |

## Verification
On every cycle the embedded assertions check that an initialization start lands in the base-word state, that the base and mask loads follow the write that carries them, and that the short sequence ends after two data words. They also check that no two operation strobes fire together, that a poll read always disarms, and that an empty poll and a mask read return the right byte. Some behaviours only the bench's scenarios can show: the full mode-word path, the selective clearing done by a restart with and without the fourth word, every command code including the no-op, and the switch between request and in-service readback. A behavioural model compares every output on every clock, alongside directed checks.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  typedef enum logic [1:0] {
    IS_RUN  = 2'd0,
    IS_BASE = 2'd1,
    IS_CASC = 2'd2,
    IS_MODE = 2'd3
  } init_st_e;
endpackage

// File: rtl/irqseq_init.sv
module irqseq_init
  import irqseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] mask,
  output logic          busy,
  output logic          init_pulse,
  output logic          sfnm,
  output logic          auto_eoi
);
  localparam logic [DW-1:0] BASE_MASK = {{(DW-LW){1'b1}}, {LW{1'b0}}};

  init_st_e st;
  logic     ic4;
  logic     start;

  assign start = cmd_wr && wdata[4];
  assign busy  = (st != IS_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IS_RUN;
      ic4        <= 1'b0;
      vec_base   <= '0;
      mask       <= '0;
      init_pulse <= 1'b0;
      sfnm       <= 1'b0;
      auto_eoi   <= 1'b0;
    end else begin
      init_pulse <= start;
      if (start) begin
        st   <= IS_BASE;
        ic4  <= wdata[0];
        mask <= '0;
        if (!wdata[0]) begin
          sfnm     <= 1'b0;
          auto_eoi <= 1'b0;
        end
      end else if (data_wr) begin
        case (st)
          IS_RUN:  mask <= wdata;
          IS_BASE: begin
            vec_base <= wdata & BASE_MASK;
            st       <= IS_CASC;
          end
          IS_CASC: st <= ic4 ? IS_MODE : IS_RUN;
          IS_MODE: begin
            sfnm     <= wdata[4];
            auto_eoi <= wdata[1];
            st       <= IS_RUN;
          end
          default: st <= IS_RUN;
        endcase
      end
    end
  end

  p_init_enter_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (st == IS_BASE) && init_pulse);

  p_base_load_r2: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !start && st == IS_BASE) |=>
      (vec_base == ($past(wdata) & BASE_MASK)) && (st == IS_CASC));

  p_short_seq_r3: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !start && st == IS_CASC && !ic4) |=> !busy);

  p_mask_load_r5: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !start && st == IS_RUN) |=> mask == $past(wdata));
endmodule

// File: rtl/irqseq_ocw.sv
module irqseq_ocw #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  input  logic          poll_taken,
  output logic          rot_auto_eoi,
  output logic          special_mask,
  output logic          rd_isr_sel,
  output logic          poll_armed,
  output logic          eoi_ns,
  output logic          eoi_sp,
  output logic          eoi_rot,
  output logic          prio_set,
  output logic [LW-1:0] cmd_line
);
  logic       start, ocw2, ocw3;
  logic [2:0] code;

  assign start = cmd_wr && wdata[4];
  assign ocw3  = cmd_wr && !wdata[4] && wdata[3];
  assign ocw2  = cmd_wr && !wdata[4] && !wdata[3];
  assign code  = wdata[7:5];

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_auto_eoi <= 1'b0;
      special_mask <= 1'b0;
      rd_isr_sel   <= 1'b0;
      poll_armed   <= 1'b0;
      eoi_ns       <= 1'b0;
      eoi_sp       <= 1'b0;
      eoi_rot      <= 1'b0;
      prio_set     <= 1'b0;
      cmd_line     <= '0;
    end else begin
      eoi_ns   <= 1'b0;
      eoi_sp   <= 1'b0;
      eoi_rot  <= 1'b0;
      prio_set <= 1'b0;
      if (poll_taken) poll_armed <= 1'b0;
      if (start) begin
        special_mask <= 1'b0;
        rd_isr_sel   <= 1'b0;
      end
      if (ocw3) begin
        if (wdata[2]) poll_armed   <= 1'b1;
        if (wdata[1]) rd_isr_sel   <= wdata[0];
        if (wdata[6]) special_mask <= wdata[5];
      end
      if (ocw2) begin
        cmd_line <= wdata[LW-1:0];
        case (code)
          3'd0, 3'd4: rot_auto_eoi <= code[2];
          3'd1:       eoi_ns <= 1'b1;
          3'd5: begin
            eoi_ns  <= 1'b1;
            eoi_rot <= 1'b1;
          end
          3'd3:       eoi_sp <= 1'b1;
          3'd7: begin
            eoi_sp  <= 1'b1;
            eoi_rot <= 1'b1;
          end
          3'd6:       prio_set <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eoi_ns, eoi_sp, prio_set}));

  p_rot_qualified_r7: assert property (@(posedge clk) disable iff (rst)
    eoi_rot |-> (eoi_ns || eoi_sp));

  p_poll_once_r8: assert property (@(posedge clk) disable iff (rst)
    (poll_taken && !(ocw3 && wdata[2])) |=> !poll_armed);
endmodule

// File: rtl/irqseq_rdback.sv
module irqseq_rdback #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          addr,
  input  logic          poll_armed,
  input  logic          rd_isr_sel,
  input  logic [DW-1:0] req_in,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] mask_in,
  input  logic          pend_valid,
  input  logic [LW-1:0] pend_line,
  output logic [DW-1:0] rdata,
  output logic          poll_clr,
  output logic [LW-1:0] poll_line
);
  localparam logic [DW-1:0] POLL_EMPTY = DW'((1 << LW) - 1);

  logic [DW-1:0] poll_word, norm_word;

  assign poll_word = pend_valid ? {1'b1, {(DW-1-LW){1'b0}}, pend_line} : POLL_EMPTY;
  assign norm_word = addr ? mask_in : (rd_isr_sel ? isr_in : req_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      poll_clr  <= 1'b0;
      poll_line <= '0;
    end else begin
      poll_clr <= rd_en && poll_armed && pend_valid;
      if (rd_en) rdata <= poll_armed ? poll_word : norm_word;
      if (rd_en && poll_armed && pend_valid) poll_line <= pend_line;
    end
  end

  p_poll_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && poll_armed && !pend_valid) |=> (rdata == POLL_EMPTY) && !poll_clr);

  p_mask_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !poll_armed && addr) |=> rdata == $past(mask_in));
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq #(
  parameter int DW    = 8,
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     addr,
  input  logic [DW-1:0]            wdata,
  input  logic [DW-1:0]            req_in,
  input  logic [DW-1:0]            isr_in,
  input  logic                     pend_valid,
  input  logic [$clog2(LINES)-1:0] pend_line,
  output logic [DW-1:0]            rdata,
  output logic [DW-1:0]            vec_base,
  output logic [DW-1:0]            mask,
  output logic                     init_busy,
  output logic                     init_pulse,
  output logic                     sfnm,
  output logic                     auto_eoi,
  output logic                     rot_auto_eoi,
  output logic                     special_mask,
  output logic                     eoi_ns,
  output logic                     eoi_sp,
  output logic                     eoi_rot,
  output logic                     prio_set,
  output logic [$clog2(LINES)-1:0] cmd_line,
  output logic                     poll_clr,
  output logic [$clog2(LINES)-1:0] poll_line
);
  localparam int LW = $clog2(LINES);

  logic cmd_wr, data_wr, rd_isr_sel, poll_armed, poll_taken;

  assign cmd_wr     = wr_en && !addr;
  assign data_wr    = wr_en && addr;
  assign poll_taken = rd_en && poll_armed;

  irqseq_init #(.DW(DW), .LW(LW)) u_init (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .data_wr(data_wr), .wdata(wdata),
    .vec_base(vec_base), .mask(mask), .busy(init_busy), .init_pulse(init_pulse),
    .sfnm(sfnm), .auto_eoi(auto_eoi)
  );

  irqseq_ocw #(.DW(DW), .LW(LW)) u_ocw (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .wdata(wdata), .poll_taken(poll_taken),
    .rot_auto_eoi(rot_auto_eoi), .special_mask(special_mask), .rd_isr_sel(rd_isr_sel),
    .poll_armed(poll_armed), .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_rot(eoi_rot),
    .prio_set(prio_set), .cmd_line(cmd_line)
  );

  irqseq_rdback #(.DW(DW), .LW(LW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .poll_armed(poll_armed),
    .rd_isr_sel(rd_isr_sel), .req_in(req_in), .isr_in(isr_in), .mask_in(mask),
    .pend_valid(pend_valid), .pend_line(pend_line), .rdata(rdata),
    .poll_clr(poll_clr), .poll_line(poll_line)
  );

  p_restart_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata[4]) |=> (mask == '0) && !special_mask);
endmodule

// File: tb/test_irq_cmd_seq.sv
module test_irq_cmd_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00, req_in = 8'h00, isr_in = 8'h00;
  logic       pend_valid = 1'b0;
  logic [2:0] pend_line = 3'd0;
  logic [7:0] rdata, vec_base, mask;
  logic       init_busy, init_pulse, sfnm, auto_eoi, rot_auto_eoi, special_mask;
  logic       eoi_ns, eoi_sp, eoi_rot, prio_set, poll_clr;
  logic [2:0] cmd_line, poll_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_cmd_seq i_irq_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .req_in(req_in), .isr_in(isr_in), .pend_valid(pend_valid), .pend_line(pend_line),
    .rdata(rdata), .vec_base(vec_base), .mask(mask), .init_busy(init_busy),
    .init_pulse(init_pulse), .sfnm(sfnm), .auto_eoi(auto_eoi),
    .rot_auto_eoi(rot_auto_eoi), .special_mask(special_mask), .eoi_ns(eoi_ns),
    .eoi_sp(eoi_sp), .eoi_rot(eoi_rot), .prio_set(prio_set), .cmd_line(cmd_line),
    .poll_clr(poll_clr), .poll_line(poll_line)
  );

  // behavioural reference: phase 0 run, 1..3 = words still to come
  int m_phase, m_rd, m_vec, m_mask, m_cl, m_pl;
  bit m_four, m_sf, m_ae, m_rot, m_smm, m_sel, m_poll;
  bit m_pulse, m_ns, m_sp, m_rq, m_pr, m_pc;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_rd = 0; m_vec = 0; m_mask = 0; m_cl = 0; m_pl = 0;
      m_four = 0; m_sf = 0; m_ae = 0; m_rot = 0; m_smm = 0; m_sel = 0; m_poll = 0;
      m_pulse = 0; m_ns = 0; m_sp = 0; m_rq = 0; m_pr = 0; m_pc = 0;
    end else begin
      m_pulse = 0; m_ns = 0; m_sp = 0; m_rq = 0; m_pr = 0; m_pc = 0;
      if (rd_en) begin
        if (m_poll) begin
          m_rd = pend_valid ? (128 + pend_line) : 7;
          if (pend_valid) begin m_pc = 1; m_pl = pend_line; end
          m_poll = 0;
        end else if (addr) m_rd = m_mask;
        else m_rd = m_sel ? isr_in : req_in;
      end
      if (wr_en && !addr) begin
        if (wdata[4]) begin
          m_phase = 1; m_four = wdata[0]; m_mask = 0; m_smm = 0; m_sel = 0; m_pulse = 1;
          if (!wdata[0]) begin m_sf = 0; m_ae = 0; end
        end else if (wdata[3]) begin
          if (wdata[2]) m_poll = 1;
          if (wdata[1]) m_sel = wdata[0];
          if (wdata[6]) m_smm = wdata[5];
        end else begin
          m_cl = wdata % 8;
          case (wdata / 32)
            0: m_rot = 0;
            4: m_rot = 1;
            1: m_ns = 1;
            5: begin m_ns = 1; m_rq = 1; end
            3: m_sp = 1;
            7: begin m_sp = 1; m_rq = 1; end
            6: m_pr = 1;
            default: ;
          endcase
        end
      end else if (wr_en && addr) begin
        if (m_phase == 0) m_mask = wdata;
        else if (m_phase == 1) begin m_vec = (wdata / 8) * 8; m_phase = 2; end
        else if (m_phase == 2) m_phase = m_four ? 3 : 0;
        else begin m_sf = wdata[4]; m_ae = wdata[1]; m_phase = 0; end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 init_pulse", init_pulse, m_pulse);
      chk("R2 vec_base", vec_base, m_vec);
      chk("R3 init_busy", init_busy, m_phase != 0);
      chk("R4 sfnm", sfnm, m_sf);
      chk("R4 auto_eoi", auto_eoi, m_ae);
      chk("R5 mask", mask, m_mask);
      chk("R6 special_mask", special_mask, m_smm);
      chk("R7 rot_auto_eoi", rot_auto_eoi, m_rot);
      chk("R7 strobes", {eoi_ns, eoi_sp, eoi_rot, prio_set}, {m_ns, m_sp, m_rq, m_pr});
      chk("R7 cmd_line", cmd_line, m_cl);
      chk("R8 poll_clr", poll_clr, m_pc);
      chk("R8 poll_line", poll_line, m_pl);
      chk("R9 rdata", rdata, m_rd);
    end
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input bit a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset rdata", rdata, 0);
    chk("R5 reset mask", mask, 0);
    chk("R3 reset busy", init_busy, 0);
    // full four-word sequence
    wr(0, 8'h11);
    wr(1, 8'h4D);
    chk("R2 base masked", vec_base, 8'h48);
    chk("R5 mask untouched by init word", mask, 8'h00);
    wr(1, 8'h04);
    chk("R3 waits for fourth word", init_busy, 1);
    wr(1, 8'h13);
    chk("R4 sfnm set", sfnm, 1);
    chk("R4 auto_eoi set", auto_eoi, 1);
    chk("R3 done after fourth", init_busy, 0);
    wr(1, 8'hA5);
    rd(1);
    chk("R9 mask readback", rdata, 8'hA5);
    // set special mask and read select, then restart with ic4 set
    wr(0, 8'h6B);
    chk("R6 special mask on", special_mask, 1);
    req_in = 8'h3C; isr_in = 8'hC1;
    rd(0);
    chk("R9 isr select", rdata, 8'hC1);
    wr(0, 8'h11);
    chk("R10 mask cleared", mask, 0);
    chk("R10 special mask cleared", special_mask, 0);
    chk("R10 sfnm kept with ic4", sfnm, 1);
    rd(0);
    chk("R10 read select cleared", rdata, 8'h3C);
    wr(1, 8'h20); wr(1, 8'h00); wr(1, 8'h00);
    // restart without fourth word
    wr(0, 8'h10);
    chk("R10 sfnm cleared", sfnm, 0);
    chk("R10 auto_eoi cleared", auto_eoi, 0);
    wr(1, 8'hF7);
    chk("R2 base", vec_base, 8'hF0);
    wr(1, 8'h00);
    chk("R3 short sequence ends", init_busy, 0);
    // every operation code
    wr(0, 8'h20); wr(0, 8'hA3); wr(0, 8'h65); wr(0, 8'hE6);
    wr(0, 8'h80);
    chk("R7 rotate-on-auto set", rot_auto_eoi, 1);
    wr(0, 8'h40); wr(0, 8'h00);
    chk("R7 rotate-on-auto clear", rot_auto_eoi, 0);
    @(negedge clk); wr_en = 1'b1; addr = 1'b0; wdata = 8'hC2;
    @(negedge clk); wr_en = 1'b0;
    chk("R7 priority strobe", prio_set, 1);
    chk("R7 priority line", cmd_line, 2);
    // read select toggling
    wr(0, 8'h0B); rd(0); wr(0, 8'h08); rd(0); wr(0, 8'h0A); rd(0);
    chk("R6 request select", rdata, 8'h3C);
    // poll hit then normal read
    wr(0, 8'h0C);
    pend_valid = 1'b1; pend_line = 3'd5;
    @(negedge clk); rd_en = 1'b1; addr = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R8 poll hit data", rdata, 8'h85);
    chk("R8 poll clear", poll_clr, 1);
    rd(1);
    chk("R8 poll disarmed", rdata, 8'h00);
    pend_valid = 1'b0;
    wr(0, 8'h0C); rd(0);
    chk("R8 poll empty", rdata, 8'h07);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      req_in = 8'($urandom); isr_in = 8'($urandom);
      pend_valid = 1'($urandom); pend_line = 3'($urandom);
      if (k < 4) wr(0, 8'($urandom));
      else if (k < 7) wr(1, 8'($urandom));
      else rd(1'($urandom));
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule